// File: doc/BRIEF.md
# Multi-Source Power-On Reset Qualifier

This block decides which class of reset a chip should take when a reset request arrives. It watches two asynchronous request sources: a dedicated reset pad, which is active high, and one general-purpose input. That input is picked from a small bus, is enabled separately and has a programmable active level. While any enabled source is active, a shared counter advances on the slow always-on clock. If the requests stay active, with no gap, for the programmed delay, the block issues a power-on reset strobe. If the pad request ends before that, the block issues a lighter hardware reset strobe instead. A rising edge on a software request input gives a software reset strobe, which is the lightest class.

The delay is held in a 7-bit register in units of `TICK_DIV` clock cycles. Only the power-up reset input and the block's own power-on strobe can reset this register. An output asks the slow oscillator to stay running whenever a source is active at its raw pin, so that qualification works even when software has turned the clock off. Every asynchronous input passes through two flip-flops before the active level is applied.

Top module: `por_reset_timer`

## Requirements
- R1: After `rst_n` is released, all three strobes are 0 and `dly_o` reads `DELAY_INIT` (24 by default).
- R2: Let L = max(`dly_o`,1) × `TICK_DIV` cycles. A pad request held for P ≥ L cycles gives exactly one `por_rst_o` pulse. It is seen in the cycle after the (L+2)-th rising clock edge that follows the request assertion, because two cycles go to synchronization.
- R3: The GPIO source is `gpio_i[gpio_sel_i]` when `gpio_en_i`=1. It counts as active when it equals `gpio_pol_i` (1 = active high, 0 = active low). Unselected bits, and every bit while `gpio_en_i`=0, have no effect.
- R4: When all sources go inactive before L cycles, the counter returns to zero, so separate short requests never add up to a power-on reset.
- R5: Overlapping requests count as one continuous request. If the pad asserts, the GPIO asserts, and the pad then releases, counting goes on, and the power-on reset comes L cycles after the first source was seen.
- R6: A request episode that included the pad and ended after P < L cycles gives one `hw_rst_o` pulse after the (P+3)-th edge. An episode with only the GPIO gives no strobe.
- R7: Each strobe lasts one cycle. After a power-on reset, no further strobe comes from the same episode, including when it is released.
- R8: `dly_wr_i` loads `dly_wdata_i` into `dly_o` at the next edge. A power-on reset strobe reloads `DELAY_INIT`.
- R9: A rising edge of `sw_req_i` gives one `sw_rst_o` pulse at the next edge, even if the request is held high. At most one strobe is high in any cycle, and the power-on or hardware reset takes precedence.
- R10: `osc_keep_on_o` is high, with no clock needed, whenever the raw pad or the raw selected, enabled GPIO is at its active level.
- R11: A programmed delay of 0 behaves as a delay of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| pad_rst_i | input | 1 | Reset pad request, active high, asynchronous |
| gpio_i | input | GPIO_W | General-purpose inputs, asynchronous |
| gpio_sel_i | input | SEL_W | Index of the GPIO used as a source |
| gpio_en_i | input | 1 | Enables the GPIO source |
| gpio_pol_i | input | 1 | Active level of the GPIO source |
| dly_wr_i | input | 1 | Delay register write strobe |
| dly_wdata_i | input | DLY_W | Delay value in ticks |
| sw_req_i | input | 1 | Software reset request level |
| por_rst_o | output | 1 | Power-on reset strobe |
| hw_rst_o | output | 1 | Hardware reset strobe |
| sw_rst_o | output | 1 | Software reset strobe |
| osc_keep_on_o | output | 1 | Keeps the slow oscillator running |
| dly_o | output | DLY_W | Current delay register value |

## Verification
If the counter or the episode flags hold a wrong value, the effect is visible at the ports within one delay window. A power-on strobe comes a cycle early or late, a hardware strobe replaces it, or a stray strobe follows the release. A missed counter clear shows up on the next short request as a power-on reset that should not happen. A bad reload shows in `dly_o` one cycle after the strobe. Sweeping every pulse length around each delay for every source mix covers the counts where these errors can occur.

// File: rtl/por_pkg.sv
package por_pkg;
  // Cycles a request must persist: zero ticks is treated as one tick.
  function automatic int unsigned por_limit(input int unsigned ticks,
                                            input int unsigned tick_div);
    int unsigned t;
    t = (ticks == 0) ? 1 : ticks;
    return t * tick_div;
  endfunction
endpackage

// File: rtl/por_sync2.sv
module por_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/por_src_sel.sv
module por_src_sel #(
  parameter int GPIO_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              pad_raw_i,
  input  logic [GPIO_W-1:0] gpio_raw_i,
  input  logic              pad_s_i,
  input  logic [GPIO_W-1:0] gpio_s_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  input  logic              pol_i,
  output logic              pad_on_o,
  output logic              src_any_o,
  output logic              keep_on_o
);
  logic gpio_on;
  assign gpio_on   = en_i & (gpio_s_i[sel_i] == pol_i);
  assign pad_on_o  = pad_s_i;
  assign src_any_o = pad_s_i | gpio_on;
  assign keep_on_o = pad_raw_i | (en_i & (gpio_raw_i[sel_i] == pol_i));
endmodule

// File: rtl/por_delay_reg.sv
module por_delay_reg #(
  parameter int               DLY_W      = 7,
  parameter logic [DLY_W-1:0] DELAY_INIT = 7'd24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_clr_i,
  input  logic             wr_i,
  input  logic [DLY_W-1:0] wdata_i,
  output logic [DLY_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_o <= DELAY_INIT;
    else if (por_clr_i) q_o <= DELAY_INIT;
    else if (wr_i)      q_o <= wdata_i;
  end

  // R8
  delay_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_clr_i |=> (q_o == DELAY_INIT));
endmodule

// File: rtl/por_qual_timer.sv
module por_qual_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_any_i,
  input  logic             pad_on_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             sw_req_i,
  output logic             por_o,
  output logic             hw_o,
  output logic             sw_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic             fired, pad_seen, sw_d;
  logic             hit, rel_hw, sw_edge;

  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  assign hit     = src_any_i & ~fired & (cnt_inc >= {1'b0, limit_i});
  assign rel_hw  = ~src_any_i & pad_seen & ~fired;
  assign sw_edge = sw_req_i & ~sw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      fired    <= 1'b0;
      pad_seen <= 1'b0;
      por_o    <= 1'b0;
      hw_o     <= 1'b0;
      sw_o     <= 1'b0;
      sw_d     <= 1'b0;
    end else begin
      if (src_any_i) begin
        if (!fired) cnt <= cnt_inc[CNT_W-1:0];
        if (hit)    fired <= 1'b1;
        pad_seen <= pad_seen | pad_on_i;
      end else begin
        cnt      <= '0;
        fired    <= 1'b0;
        pad_seen <= 1'b0;
      end
      por_o <= hit;
      hw_o  <= rel_hw;
      sw_o  <= sw_edge & ~hit & ~rel_hw;
      sw_d  <= sw_req_i;
    end
  end

  // R7
  por_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |=> !por_o);
  // R7
  hw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_o |=> !hw_o);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({por_o, hw_o, sw_o}));
  // R4
  clear_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_any_i |=> (cnt == '0));
  // R2
  por_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |-> $past(src_any_i));
endmodule

// File: rtl/por_reset_timer.sv
module por_reset_timer #(
  parameter int               GPIO_W     = 4,
  parameter int               SEL_W      = $clog2(GPIO_W),
  parameter int               DLY_W      = 7,
  parameter int               TICK_DIV   = 4,
  parameter logic [DLY_W-1:0] DELAY_INIT = 7'd24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_rst_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic [SEL_W-1:0]  gpio_sel_i,
  input  logic              gpio_en_i,
  input  logic              gpio_pol_i,
  input  logic              dly_wr_i,
  input  logic [DLY_W-1:0]  dly_wdata_i,
  input  logic              sw_req_i,
  output logic              por_rst_o,
  output logic              hw_rst_o,
  output logic              sw_rst_o,
  output logic              osc_keep_on_o,
  output logic [DLY_W-1:0]  dly_o
);
  import por_pkg::*;

  localparam int MAX_LIM = ((1 << DLY_W) - 1) * TICK_DIV;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);

  logic [GPIO_W:0]  raw_bus, sync_bus;
  logic             pad_on, src_any;
  logic [CNT_W-1:0] limit;

  assign raw_bus = {pad_rst_i, gpio_i};

  por_sync2 #(.W(GPIO_W + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_bus), .q_o(sync_bus)
  );

  por_src_sel #(.GPIO_W(GPIO_W), .SEL_W(SEL_W)) u_sel (
    .pad_raw_i(pad_rst_i), .gpio_raw_i(gpio_i),
    .pad_s_i(sync_bus[GPIO_W]), .gpio_s_i(sync_bus[GPIO_W-1:0]),
    .sel_i(gpio_sel_i), .en_i(gpio_en_i), .pol_i(gpio_pol_i),
    .pad_on_o(pad_on), .src_any_o(src_any), .keep_on_o(osc_keep_on_o)
  );

  por_delay_reg #(.DLY_W(DLY_W), .DELAY_INIT(DELAY_INIT)) u_dly (
    .clk(clk), .rst_n(rst_n), .por_clr_i(por_rst_o),
    .wr_i(dly_wr_i), .wdata_i(dly_wdata_i), .q_o(dly_o)
  );

  assign limit = CNT_W'(por_limit(int'(dly_o), TICK_DIV));

  por_qual_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .src_any_i(src_any), .pad_on_i(pad_on),
    .limit_i(limit), .sw_req_i(sw_req_i),
    .por_o(por_rst_o), .hw_o(hw_rst_o), .sw_o(sw_rst_o)
  );
endmodule

// File: tb/sim_por_reset_timer.sv
`timescale 1ns/100ps
module sim_por_reset_timer;
  localparam int GW = 4;
  localparam int TD = 4;
  localparam int DINIT = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pad = 1'b0;
  logic [GW-1:0] gpio = '0;
  logic [1:0]    sel = 2'd2;
  logic          en = 1'b1;
  logic          pol = 1'b1;
  logic          wr = 1'b0;
  logic [6:0]    wdata = '0;
  logic          swr = 1'b0;
  logic          por, hw, sw, keep;
  logic [6:0]    dly;

  int checks = 0, errors = 0, cyc = 0, overlaps = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  por_reset_timer u0 (
    .clk(clk), .rst_n(rst_n), .pad_rst_i(pad), .gpio_i(gpio),
    .gpio_sel_i(sel), .gpio_en_i(en), .gpio_pol_i(pol),
    .dly_wr_i(wr), .dly_wdata_i(wdata), .sw_req_i(swr),
    .por_rst_o(por), .hw_rst_o(hw), .sw_rst_o(sw),
    .osc_keep_on_o(keep), .dly_o(dly)
  );

  always @(posedge clk) begin
    cyc++;
    #1;
    if (int'(por) + int'(hw) + int'(sw) > 1) overlaps++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_delay(input int d);
    @(negedge clk); wr = 1'b1; wdata = 7'(d);
    @(negedge clk); wr = 1'b0;
    chk(dly == 7'(d), "R8", int'(dly), d);
  endtask

  // mode 0 pad, 1 gpio high, 2 gpio low, 3 pad then gpio overlap
  task automatic pulse(input int mode, input int d, input int p);
    int lim, por_at, hw_at, np, nh, idle;
    bit padded, exp_por;
    string rq;
    lim = ((d == 0) ? 1 : d) * TD;
    padded = (mode == 0 || mode == 3);
    exp_por = (p >= lim);
    idle = (mode == 2) ? 1 : 0;
    @(negedge clk);
    sel = 2'd2; en = 1'b1; pol = (mode == 2) ? 1'b0 : 1'b1;
    gpio = (mode == 2) ? '1 : '0; pad = 1'b0;
    repeat (4) @(negedge clk);
    set_delay(d);
    repeat (2) @(negedge clk);
    case (mode)
      0, 3: pad = 1'b1;
      1: gpio[2] = 1'b1;
      default: gpio[2] = 1'b0;
    endcase
    #1 chk(keep == 1'b1, "R10", int'(keep), 1);
    por_at = 0; hw_at = 0; np = 0; nh = 0;
    for (int k = 1; k <= p + lim + 8; k++) begin
      @(posedge clk); #1;
      if (por) begin np++; if (por_at == 0) por_at = k; end
      if (hw)  begin nh++; if (hw_at == 0) hw_at = k; end
      if (mode == 3 && k == 2) begin @(negedge clk); gpio[2] = 1'b1; end
      if (mode == 3 && k == 3) begin @(negedge clk); pad = 1'b0; end
      if (k == p) begin @(negedge clk); pad = 1'b0; gpio[2] = idle[0]; end
    end
    chk(keep == 1'b0, "R10", int'(keep), 0);
    rq = (mode == 3) ? "R5" : (mode != 0) ? "R3" : (d == 0) ? "R11" : "R2";
    if (exp_por) begin
      chk(np == 1, rq, np, 1);
      chk(por_at == lim + 2, rq, por_at, lim + 2);
      chk(nh == 0, "R7", nh, 0);
      chk(dly == 7'(DINIT), "R8", int'(dly), DINIT);
    end else begin
      chk(np == 0, "R4", np, 0);
      chk(nh == (padded ? 1 : 0), "R6", nh, padded ? 1 : 0);
      if (padded) chk(hw_at == p + 3, "R6", hw_at, p + 3);
    end
  endtask

  task automatic quiet_run(input string rq, input int n);
    int cnt;
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (por || hw || sw) cnt++;
      if (keep) cnt++;
    end
    chk(cnt == 0, rq, cnt, 0);
  endtask

  initial begin
    int ds[5] = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    chk({por, hw, sw} == 3'b000, "R1", int'({por, hw, sw}), 0);
    chk(dly == 7'(DINIT), "R1", int'(dly), DINIT);

    for (int m = 0; m < 4; m++)
      foreach (ds[i]) begin
        int lim;
        lim = ((ds[i] == 0) ? 1 : ds[i]) * TD;
        for (int p = (m == 3 ? 4 : 1); p <= lim + 2; p++) pulse(m, ds[i], p);
      end

    // R3: unselected bit and disabled source are ignored
    @(negedge clk); pol = 1'b1; gpio = '0; sel = 2'd2; en = 1'b1;
    set_delay(1);
    @(negedge clk); gpio[1] = 1'b1;
    quiet_run("R3", 40);
    @(negedge clk); gpio = '0; en = 1'b0;
    @(negedge clk); gpio[2] = 1'b1;
    quiet_run("R3", 40);
    @(negedge clk); gpio = '0; en = 1'b1;
    chk(dly == 7'd1, "R3", int'(dly), 1);

    // R9: software request edge
    begin
      int ns, at;
      ns = 0; at = 0;
      repeat (4) @(negedge clk);
      swr = 1'b1;
      for (int k = 1; k <= 8; k++) begin
        @(posedge clk); #1;
        if (sw) begin ns++; if (at == 0) at = k; end
      end
      @(negedge clk); swr = 1'b0;
      chk(ns == 1, "R9", ns, 1);
      chk(at == 1, "R9", at, 1);
    end
    chk(overlaps == 0, "R9", overlaps, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule